// File: doc/BRIEF.md
# Multi-Outcome Global History Branch Direction Predictor

This block predicts the direction of two or three conditional branches in one cycle from a single global outcome history and one shared table of two-bit saturating counters. The first answer comes from the counter chosen by the full history. Later answers come from small groups of neighbouring counters, read with a shorter slice of that history. The answers already produced in the same cycle then pick one counter from each group. The directions appear combinationally in the cycle of the request, together with the counter index behind each answer. The fetch stage can then hand those indices down the pipeline.

Two copies of the history are kept. A speculative copy advances on every request by the outcomes just predicted. A committed copy advances only on the retirement port, by the resolved outcomes of retired branches. On a misprediction the fetch stage raises a flush, which reloads the speculative copy from the committed one. The retirement port also trains the counters named by the returned indices. Target addresses, return prediction and per-address history belong to other blocks.

Top module: `mbp_predictor`

## Requirements
- R1: After reset every counter holds binary 01 and both histories are zero, so all predictions read not-taken and every reported index is zero.
- R2: Prediction 0 (pred_o bit 0) is the upper bit of the counter whose index is the whole speculative history, with the most recent outcome in bit 0. Its index is reported in pred_idx_o bits [HIST_W-1:0].
- R3: Prediction 1 reads the pair of counters addressed by the low HIST_W-1 history bits. Prediction 0 picks the pair member, so the index is {history[HIST_W-2:0], pred0}, reported in pred_idx_o slice 1.
- R4: With NPRED=3, prediction 2 reads the group of four counters addressed by the low HIST_W-2 history bits. The index is {history[HIST_W-3:0], pred0, pred1}, reported in slice 2.
- R5: A retirement update moves a counter up on taken and down on not-taken, saturating at 3 and at 0. A counter predicts taken when its value is 2 or 3.
- R6: A request shifts all NPRED predictions into the speculative history, oldest first, so that the last prediction lands in bit 0. The shift is seen from the next cycle.
- R7: The committed history shifts in upd_taken_i bits 0 to upd_cnt_i-1, oldest first, on each valid update. A flush loads the speculative history with the committed value that includes the same cycle's update.
- R8: When flush and request arrive in the same cycle, the flush decides the next speculative history.
- R9: A prediction read in the same cycle as an update of the same counter returns the value from before the update. The new value is seen from the next cycle.
- R10: Without request or flush the speculative history holds its value.
- R11: An update with upd_valid_i low, or with upd_cnt_i zero, changes no counter and no history.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_i | input | 1 | Prediction request; advances the speculative history |
| flush_i | input | 1 | Mispredict recovery; reload speculative history from committed |
| pred_o | output | NPRED | Predicted directions, bit 0 oldest, 1 = taken |
| pred_idx_o | output | NPRED*HIST_W | Counter index used for each prediction, slice j for prediction j |
| upd_valid_i | input | 1 | Retirement update strobe |
| upd_cnt_i | input | CNT_W | Number of retired branches in this update (0..NPRED) |
| upd_taken_i | input | NPRED | Resolved outcomes, bit 0 oldest |
| upd_idx_i | input | NPRED*HIST_W | Counter index for each retired branch |

## Verification
Directions and indices have no register between the history and the outputs, so the bench reads them in the same cycle as the stimulus. That cycle ends before the clock edge: inputs change on the falling edge and outputs are read a moment later. Counter training, history shifts and flush reloads take effect at the next rising edge. Their results are therefore checked only after the following falling edge. The one exception is the check that an update to the counter being read still shows the old value, which is made before that edge on purpose. Saturation at each end is observed as the number of opposite updates needed before the predicted direction flips.

// File: rtl/mbp_pkg.sv
package mbp_pkg;

  typedef logic [1:0] ctr_t;

  localparam ctr_t CTR_INIT = 2'b01;
  localparam ctr_t CTR_MAX  = 2'b11;
  localparam ctr_t CTR_MIN  = 2'b00;

  function automatic ctr_t ctr_step(input ctr_t cur, input logic taken);
    ctr_t res;
    if (taken) res = (cur == CTR_MAX) ? CTR_MAX : cur + 2'd1;
    else       res = (cur == CTR_MIN) ? CTR_MIN : cur - 2'd1;
    return res;
  endfunction

endpackage

// File: rtl/mbp_history.sv
module mbp_history #(
  parameter int HIST_W = 10,
  parameter int NPRED  = 3,
  parameter int CNT_W  = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_i,
  input  logic              flush_i,
  input  logic [NPRED-1:0]  pred_i,
  input  logic              upd_valid_i,
  input  logic [CNT_W-1:0]  upd_cnt_i,
  input  logic [NPRED-1:0]  upd_taken_i,
  output logic [HIST_W-1:0] spec_hist_o
);

  logic [HIST_W-1:0] spec_q;
  logic [HIST_W-1:0] commit_q;
  logic [HIST_W-1:0] commit_nxt;
  logic [NPRED-1:0]  pred_rev;

  // oldest prediction goes deepest, newest lands in bit 0
  always_comb begin
    for (int b = 0; b < NPRED; b++) pred_rev[NPRED-1-b] = pred_i[b];
  end

  always_comb begin
    commit_nxt = commit_q;
    if (upd_valid_i) begin
      for (int s = 0; s < NPRED; s++) begin
        if (CNT_W'(s) < upd_cnt_i) commit_nxt = {commit_nxt[HIST_W-2:0], upd_taken_i[s]};
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      spec_q   <= '0;
      commit_q <= '0;
    end else begin
      commit_q <= commit_nxt;
      if (flush_i)    spec_q <= commit_nxt;
      else if (req_i) spec_q <= {spec_q[HIST_W-1-NPRED:0], pred_rev};
    end
  end

  assign spec_hist_o = spec_q;

  p_req_shift_r6: assert property (@(posedge clk) disable iff (rst)
    (req_i && !flush_i) |=> (spec_q[NPRED-1:0] == $past(pred_rev)));

  p_hold_idle_r10: assert property (@(posedge clk) disable iff (rst)
    (!req_i && !flush_i) |=> $stable(spec_q));

  p_flush_load_r7: assert property (@(posedge clk) disable iff (rst)
    (flush_i && !req_i) |=> (spec_q == commit_q));

  p_flush_wins_r8: assert property (@(posedge clk) disable iff (rst)
    (flush_i && req_i) |=> (spec_q == commit_q));

endmodule

// File: rtl/mbp_table.sv
module mbp_table
  import mbp_pkg::*;
#(
  parameter int HIST_W = 10,
  parameter int NPRED  = 3,
  parameter int CNT_W  = 2
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic [HIST_W-1:0]        hist_i,
  output logic [NPRED-1:0]         pred_o,
  output logic [NPRED*HIST_W-1:0]  pred_idx_o,
  input  logic                     upd_valid_i,
  input  logic [CNT_W-1:0]         upd_cnt_i,
  input  logic [NPRED-1:0]         upd_taken_i,
  input  logic [NPRED*HIST_W-1:0]  upd_idx_i
);

  localparam int DEPTH = 1 << HIST_W;

  ctr_t tbl [DEPTH];

  // one read stage per prediction; stage j reads 2^j neighbours and
  // selects with the path of earlier predictions from this cycle
  for (genvar j = 0; j < NPRED; j++) begin : g_rd
    localparam int GRP = 1 << j;
    logic [HIST_W-1:0] base;
    logic [GRP-1:0]    grp;
    logic [j:0]        path;
    logic              bit_q;
    logic [HIST_W-1:0] idx;

    assign base = HIST_W'(hist_i << j);

    always_comb begin
      for (int g = 0; g < GRP; g++) grp[g] = tbl[base | HIST_W'(g)][1];
    end

    if (j == 0) begin : g_first
      assign bit_q = grp[0];
      assign idx   = base;
      assign path  = bit_q;
    end else begin : g_next
      logic [j-1:0] sel;
      assign sel   = g_rd[j-1].path;
      assign bit_q = grp[sel];
      assign idx   = base | HIST_W'(sel);
      assign path  = {sel, bit_q};
    end

    assign pred_o[j]                   = bit_q;
    assign pred_idx_o[j*HIST_W +: HIST_W] = idx;
  end

  // training: later slots win if two retired branches share a counter
  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < DEPTH; i++) tbl[i] <= CTR_INIT;
    end else if (upd_valid_i) begin
      for (int s = 0; s < NPRED; s++) begin
        if (CNT_W'(s) < upd_cnt_i)
          tbl[upd_idx_i[s*HIST_W +: HIST_W]] <=
            ctr_step(tbl[upd_idx_i[s*HIST_W +: HIST_W]], upd_taken_i[s]);
      end
    end
  end

  // checking support for slot 0
  logic [HIST_W-1:0] idx0;
  ctr_t              old0;
  logic              alone0;
  logic              sat_v, idle_v;
  logic [HIST_W-1:0] chk_idx;
  ctr_t              chk_val;

  assign idx0 = upd_idx_i[HIST_W-1:0];
  assign old0 = tbl[idx0];

  always_comb begin
    alone0 = 1'b1;
    for (int s = 1; s < NPRED; s++) begin
      if ((CNT_W'(s) < upd_cnt_i) && (upd_idx_i[s*HIST_W +: HIST_W] == idx0)) alone0 = 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sat_v   <= 1'b0;
      idle_v  <= 1'b0;
      chk_idx <= '0;
      chk_val <= CTR_INIT;
    end else begin
      sat_v   <= upd_valid_i && (upd_cnt_i != '0) && alone0 &&
                 ((old0 == CTR_MAX && upd_taken_i[0]) || (old0 == CTR_MIN && !upd_taken_i[0]));
      idle_v  <= !upd_valid_i || (upd_cnt_i == '0);
      chk_idx <= idx0;
      chk_val <= old0;
    end
  end

  p_sat_hold_r5: assert property (@(posedge clk) disable iff (rst)
    sat_v |-> (tbl[chk_idx] == chk_val));

  p_no_update_r11: assert property (@(posedge clk) disable iff (rst)
    idle_v |-> (tbl[chk_idx] == chk_val));

endmodule

// File: rtl/mbp_predictor.sv
module mbp_predictor #(
  parameter int HIST_W = 10,
  parameter int NPRED  = 3,
  localparam int CNT_W = $clog2(NPRED + 1)
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     req_i,
  input  logic                     flush_i,
  output logic [NPRED-1:0]         pred_o,
  output logic [NPRED*HIST_W-1:0]  pred_idx_o,
  input  logic                     upd_valid_i,
  input  logic [CNT_W-1:0]         upd_cnt_i,
  input  logic [NPRED-1:0]         upd_taken_i,
  input  logic [NPRED*HIST_W-1:0]  upd_idx_i
);

  logic [HIST_W-1:0] spec_hist;
  logic [NPRED-1:0]  pred;

  mbp_history #(.HIST_W(HIST_W), .NPRED(NPRED), .CNT_W(CNT_W)) u_hist (
    .clk         (clk),
    .rst         (rst),
    .req_i       (req_i),
    .flush_i     (flush_i),
    .pred_i      (pred),
    .upd_valid_i (upd_valid_i),
    .upd_cnt_i   (upd_cnt_i),
    .upd_taken_i (upd_taken_i),
    .spec_hist_o (spec_hist)
  );

  mbp_table #(.HIST_W(HIST_W), .NPRED(NPRED), .CNT_W(CNT_W)) u_tbl (
    .clk         (clk),
    .rst         (rst),
    .hist_i      (spec_hist),
    .pred_o      (pred),
    .pred_idx_o  (pred_idx_o),
    .upd_valid_i (upd_valid_i),
    .upd_cnt_i   (upd_cnt_i),
    .upd_taken_i (upd_taken_i),
    .upd_idx_i   (upd_idx_i)
  );

  assign pred_o = pred;

  p_idx0_tracks_r2: assert property (@(posedge clk) disable iff (rst)
    (req_i && !flush_i) |=> (pred_idx_o[NPRED-1:0] == $past(pred_o[0]) ? 1'b1 :
      (pred_idx_o[0] == $past(pred_o[NPRED-1]))));

endmodule

// File: tb/mbp_predictor_tb.sv
module mbp_predictor_tb;

  localparam int K = 10;
  localparam int N = 3;
  localparam int CW = 2;

  logic           clk = 1'b0;
  logic           rst;
  logic           req, flush;
  logic [N-1:0]   pred;
  logic [N*K-1:0] pidx;
  logic           uv;
  logic [CW-1:0]  ucnt;
  logic [N-1:0]   utk;
  logic [N*K-1:0] uidx;

  int checks = 0;
  int errors = 0;
  int mcommit = 0;

  always #4 clk = ~clk;

  mbp_predictor #(.HIST_W(K), .NPRED(N)) u_dut (
    .clk(clk), .rst(rst), .req_i(req), .flush_i(flush),
    .pred_o(pred), .pred_idx_o(pidx),
    .upd_valid_i(uv), .upd_cnt_i(ucnt), .upd_taken_i(utk), .upd_idx_i(uidx)
  );

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic int ix(input int j);
    return int'(pidx[j*K +: K]);
  endfunction

  task automatic step();
    @(posedge clk);
    @(negedge clk);
    #1;
  endtask

  task automatic upd(input int cnt, input logic [N-1:0] tk, input int i0, input int i1, input int i2);
    uv = 1'b1; ucnt = CW'(cnt); utk = tk;
    uidx = {K'(i2), K'(i1), K'(i0)};
    for (int s = 0; s < cnt; s++) mcommit = ((mcommit << 1) | int'(tk[s])) & ((1 << K) - 1);
    step();
    uv = 1'b0; ucnt = '0; utk = '0; uidx = '0;
    #1;
  endtask

  task automatic t_reset();
    chk("R1 preds", int'(pred), 0);
    chk("R1 idx0", ix(0), 0);
    chk("R1 idx2", ix(2), 0);
  endtask

  task automatic t_first_second();
    upd(1, 3'b001, 0, 0, 0);
    chk("R2 pred0 after train", int'(pred[0]), 1);
    chk("R3 idx1", ix(1), 1);
    chk("R3 pred1", int'(pred[1]), 0);
    chk("R4 idx2", ix(2), 2);
  endtask

  task automatic t_same_cycle();
    uv = 1'b1; ucnt = 2'd1; utk = 3'b001; uidx = {K'(0), K'(0), K'(1)};
    mcommit = ((mcommit << 1) | 1) & ((1 << K) - 1);
    #1;
    chk("R9 old value during update", int'(pred[1]), 0);
    @(posedge clk); @(negedge clk);
    uv = 1'b0; ucnt = '0; utk = '0; uidx = '0;
    #1;
    chk("R9 new value next cycle", int'(pred[1]), 1);
    chk("R4 idx2 with two taken", ix(2), 3);
    upd(1, 3'b001, 3, 0, 0);
    chk("R4 pred2 from group of four", int'(pred), 7);
  endtask

  task automatic t_request();
    req = 1'b1; step(); req = 1'b0; #1;
    chk("R6 idx0 after shift", ix(0), 7);
    chk("R3 idx1 after shift", ix(1), 14);
    chk("R4 idx2 after shift", ix(2), 28);
    step(); step(); step();
    chk("R10 idle hold", ix(0), 7);
    req = 1'b1; step(); req = 1'b0; #1;
    chk("R6 second shift", ix(0), 56);
  endtask

  task automatic t_flush();
    upd(3, 3'b101, 100, 101, 102);
    chk("R7 committed model", mcommit, 61);
    req = 1'b1; flush = 1'b1; step(); req = 1'b0; flush = 1'b0; #1;
    chk("R8 flush beats request", ix(0), 61);
  endtask

  task automatic t_saturate();
    for (int n = 0; n < 5; n++) upd(1, 3'b001, 61, 0, 0);
    chk("R5 taken at top", int'(pred[0]), 1);
    upd(1, 3'b000, 61, 0, 0);
    chk("R5 saturated at 3", int'(pred[0]), 1);
    upd(1, 3'b000, 61, 0, 0);
    chk("R5 weak not-taken", int'(pred[0]), 0);
    for (int n = 0; n < 3; n++) upd(1, 3'b000, 61, 0, 0);
    upd(1, 3'b001, 61, 0, 0);
    chk("R5 saturated at 0", int'(pred[0]), 0);
    upd(1, 3'b001, 61, 0, 0);
    chk("R5 climb from bottom", int'(pred[0]), 1);
  endtask

  task automatic t_ignored();
    upd(1, 3'b000, 61, 0, 0);
    chk("R11 setup weak not-taken", int'(pred[0]), 0);
    upd(0, 3'b111, 61, 61, 61);
    chk("R11 zero count ignored", int'(pred[0]), 0);
    uv = 1'b0; ucnt = 2'd3; utk = 3'b111; uidx = {K'(61), K'(61), K'(61)};
    step();
    ucnt = '0; utk = '0; uidx = '0; #1;
    chk("R11 invalid ignored", int'(pred[0]), 0);
    flush = 1'b1; step(); flush = 1'b0; #1;
    chk("R7 committed history after ignored updates", ix(0), mcommit);
  endtask

  initial begin
    #(8 * 200000);
    errors++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    rst = 1'b1; req = 1'b0; flush = 1'b0;
    uv = 1'b0; ucnt = '0; utk = '0; uidx = '0;
    step(); step();
    rst = 1'b0; #1;
    t_reset();
    t_first_second();
    t_same_cycle();
    t_request();
    t_flush();
    t_saturate();
    t_ignored();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule